// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations. Each slot records a virtual page tag and a physical page number. It also records the address-space number that owns the mapping, a global flag, per-privilege-mode read and write enable masks, and two fault-on-access flags. A lookup presents a virtual page number, the current address-space number and the page offset. In the same cycle, with no register in the path, the block returns a hit flag, the index of the matching slot, that slot's fields and the assembled physical address.

Slots are filled at a single round-robin victim pointer. Three invalidation operations are provided:

- clearing every slot;
- dropping every mapping that is not global, for example on an address-space switch;
- dropping the mappings that a given page and address space would hit.

A separate port shows the slot under the victim pointer and can step the pointer without writing. Walking page tables and judging permissions are left to the surrounding logic.

Top module: `astlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is 1 or whose address-space number equals `lk_asn`. On a miss, `lk_hit` is 0.
- R2: When several slots match a lookup, `lk_idx` and the returned fields come from the lowest-numbered matching slot.
- R3: An insert (`ins_valid`=1 with no flush requested) writes all fields into the slot at `vic_idx` and marks it valid. The pointer then advances by one and wraps from ENTRIES-1 to 0. The written slot is visible to lookups from the next cycle.
- R4: Flush-all (`fl_all`) clears every slot to zero and sets `vic_idx` to 0 at the clock edge.
- R5: Flush-non-global (`fl_nonglob`) invalidates every slot whose global flag is 0 and leaves global slots valid.
- R6: Flush-by-address (`fl_addr`) invalidates every slot that a lookup of (`fl_vpn`, `fl_asn`) would match under the rule of R1, and no other slot.
- R7: `lk_paddr` equals `{lk_ppn, lk_off}`, which is the page number shifted left by OFF_W plus the offset.
- R8: `vic_valid`, `vic_vpn` and `vic_ppn` show the slot at `vic_idx`. `vic_adv`=1 steps the pointer by one (with the same wrap) and changes no slot. Together with an insert, the pointer steps only once.
- R9: Concurrent requests are resolved by the priority fl_all > fl_nonglob > fl_addr > insert. Only the highest is carried out. An insert that loses leaves the slots and the pointer unchanged.
- R10: After reset (`rst_n`=0 at a clock edge, synchronous), every slot is invalid, `vic_idx` is 0 and no lookup hits.
- R11: On a hit, `lk_glob`, `lk_asn`, `lk_rd_en`, `lk_wr_en`, `lk_flt_rd` and `lk_flt_wr` return the values written by the insert that filled the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_off | input | OFF_W | Lookup page offset |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Index of matching slot |
| lk_ppn | output | PPN_W | Physical page number of hit |
| lk_asn_o | output | ASN_W | Address-space number stored in hit slot |
| lk_glob | output | 1 | Global flag of hit slot |
| lk_rd_en | output | MODES | Per-mode read enables of hit slot |
| lk_wr_en | output | MODES | Per-mode write enables of hit slot |
| lk_flt_rd | output | 1 | Fault-on-read flag of hit slot |
| lk_flt_wr | output | 1 | Fault-on-write flag of hit slot |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Insert virtual page number |
| ins_ppn | input | PPN_W | Insert physical page number |
| ins_asn | input | ASN_W | Insert address-space number |
| ins_glob | input | 1 | Insert global flag |
| ins_rd_en | input | MODES | Insert read enables |
| ins_wr_en | input | MODES | Insert write enables |
| ins_flt_rd | input | 1 | Insert fault-on-read |
| ins_flt_wr | input | 1 | Insert fault-on-write |
| fl_all | input | 1 | Flush every slot |
| fl_nonglob | input | 1 | Flush non-global slots |
| fl_addr | input | 1 | Flush slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Flush-by-address page number |
| fl_asn | input | ASN_W | Flush-by-address address-space number |
| vic_adv | input | 1 | Step victim pointer |
| vic_idx | output | IDX_W | Victim pointer |
| vic_valid | output | 1 | Valid flag of slot at pointer |
| vic_vpn | output | VPN_W | Tag of slot at pointer |
| vic_ppn | output | PPN_W | Page number of slot at pointer |

## Verification
The bench loads the same page under several address spaces, with and without the global flag. This separates a matcher that ignores the address-space number (it would hit for a foreign space) from one that ignores the global flag (a shared page would miss).

Overlapping matches expose an encoder that favours the highest index. A flush-by-address that hits both a global and a private copy catches a flush that skips global slots, or one that removes too many.

A ninth insert into eight slots shows whether the pointer wraps or escapes. Inserts raised together with flushes reveal a wrong priority, which would leave a stale mapping or move the pointer.

// File: rtl/astlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: only one state-changing operation is applied per cycle.
package astlb_pkg;
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_CLR_ALL   = 3'd1,
        OP_CLR_LOCAL = 3'd2,
        OP_CLR_PAGE  = 3'd3,
        OP_FILL      = 3'd4
    } tlb_op_t;
endpackage

// File: rtl/astlb_opsel.sv
// Reduces the concurrent request lines to one operation per cycle.
// Assumes: priority is clear-all, clear-local, clear-page, then fill.
module astlb_opsel
    import astlb_pkg::*;
(
    input  logic    req_all,
    input  logic    req_local,
    input  logic    req_page,
    input  logic    req_fill,
    output tlb_op_t op
);
    // Fixed-priority choice of the operation to apply.
    always_comb begin
        if (req_all)        op = OP_CLR_ALL;
        else if (req_local) op = OP_CLR_LOCAL;
        else if (req_page)  op = OP_CLR_PAGE;
        else if (req_fill)  op = OP_FILL;
        else                op = OP_NONE;
    end
endmodule

// File: rtl/astlb_entry.sv
// One translation slot: stores the fields and matches lookups and page flushes.
// Assumes: op is already decoded; sel marks this slot as the fill target.
module astlb_entry
    import astlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int ASN_W = 8,
    parameter int MODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tlb_op_t          op,
    input  logic             sel,
    input  logic [VPN_W-1:0] w_vpn,
    input  logic [PPN_W-1:0] w_ppn,
    input  logic [ASN_W-1:0] w_asn,
    input  logic             w_glob,
    input  logic [MODES-1:0] w_rd,
    input  logic [MODES-1:0] w_wr,
    input  logic             w_frd,
    input  logic             w_fwr,
    input  logic [VPN_W-1:0] f_vpn,
    input  logic [ASN_W-1:0] f_asn,
    input  logic [VPN_W-1:0] q_vpn,
    input  logic [ASN_W-1:0] q_asn,
    output logic             valid,
    output logic [VPN_W-1:0] vpn,
    output logic [PPN_W-1:0] ppn,
    output logic [ASN_W-1:0] asn,
    output logic             glob,
    output logic [MODES-1:0] rd_en,
    output logic [MODES-1:0] wr_en,
    output logic             frd,
    output logic             fwr,
    output logic             q_match
);
    logic f_match;

    // Lookup match: valid, equal tag, and shared or same address space.
    assign q_match = valid && (vpn == q_vpn) && (glob || (asn == q_asn));
    // Page-flush match uses the same rule on the flush operands.
    assign f_match = valid && (vpn == f_vpn) && (glob || (asn == f_asn));

    // Slot state update for fill and the three invalidation kinds.
    always_ff @(posedge clk) begin
        if (!rst_n || op == OP_CLR_ALL) begin
            valid <= 1'b0;
            vpn   <= '0;
            ppn   <= '0;
            asn   <= '0;
            glob  <= 1'b0;
            rd_en <= '0;
            wr_en <= '0;
            frd   <= 1'b0;
            fwr   <= 1'b0;
        end else if (op == OP_FILL && sel) begin
            valid <= 1'b1;
            vpn   <= w_vpn;
            ppn   <= w_ppn;
            asn   <= w_asn;
            glob  <= w_glob;
            rd_en <= w_rd;
            wr_en <= w_wr;
            frd   <= w_frd;
            fwr   <= w_fwr;
        end else if (op == OP_CLR_LOCAL && !glob) begin
            valid <= 1'b0;
        end else if (op == OP_CLR_PAGE && f_match) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/astlb_prio.sv
// Lowest-index-first encoder over the per-slot match lines.
// Assumes: N >= 2.
module astlb_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     m,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is the last written.
    always_comb begin
        any = |m;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/astlb_victim.sv
// Round-robin replacement pointer with wrap at the last slot.
// Assumes: clr wins over step.
module astlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    // Pointer update: clear, advance with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  ptr <= '0;
        else if (step)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/astlb.sv
// Fully associative translation buffer tagged by address-space number.
// Lookup is combinational; fill and flushes act at the rising clock edge.
// Assumes: synchronous active-low reset; ENTRIES >= 2.
module astlb
    import astlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ASN_W   = 8,
    parameter int OFF_W   = 13,
    parameter int MODES   = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic [OFF_W-1:0] lk_off,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [ASN_W-1:0] lk_asn_o,
    output logic             lk_glob,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_flt_rd,
    output logic             lk_flt_wr,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_glob,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_flt_rd,
    input  logic             ins_flt_wr,
    input  logic             fl_all,
    input  logic             fl_nonglob,
    input  logic             fl_addr,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             vic_adv,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_valid,
    output logic [VPN_W-1:0] vic_vpn,
    output logic [PPN_W-1:0] vic_ppn
);
    tlb_op_t                     op;
    logic [ENTRIES-1:0]          ent_valid;
    logic [ENTRIES-1:0]          ent_glob;
    logic [ENTRIES-1:0]          ent_frd;
    logic [ENTRIES-1:0]          ent_fwr;
    logic [ENTRIES-1:0]          ent_match;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
    logic [ENTRIES-1:0][ASN_W-1:0] ent_asn;
    logic [ENTRIES-1:0][MODES-1:0] ent_rd;
    logic [ENTRIES-1:0][MODES-1:0] ent_wr;
    logic                        hit_any;
    logic [IDX_W-1:0]            hit_idx;

    astlb_opsel u_opsel (
        .req_all   (fl_all),
        .req_local (fl_nonglob),
        .req_page  (fl_addr),
        .req_fill  (ins_valid),
        .op        (op)
    );

    astlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (op == OP_CLR_ALL),
        .step  ((op == OP_FILL) || vic_adv),
        .ptr   (vic_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        astlb_entry #(
            .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .sel     (vic_idx == IDX_W'(g)),
            .w_vpn   (ins_vpn),
            .w_ppn   (ins_ppn),
            .w_asn   (ins_asn),
            .w_glob  (ins_glob),
            .w_rd    (ins_rd_en),
            .w_wr    (ins_wr_en),
            .w_frd   (ins_flt_rd),
            .w_fwr   (ins_flt_wr),
            .f_vpn   (fl_vpn),
            .f_asn   (fl_asn),
            .q_vpn   (lk_vpn),
            .q_asn   (lk_asn),
            .valid   (ent_valid[g]),
            .vpn     (ent_vpn[g]),
            .ppn     (ent_ppn[g]),
            .asn     (ent_asn[g]),
            .glob    (ent_glob[g]),
            .rd_en   (ent_rd[g]),
            .wr_en   (ent_wr[g]),
            .frd     (ent_frd[g]),
            .fwr     (ent_fwr[g]),
            .q_match (ent_match[g])
        );
    end

    astlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .m   (ent_match),
        .any (hit_any),
        .idx (hit_idx)
    );

    // Return the chosen slot's fields, zero on a miss.
    always_comb begin
        lk_hit    = hit_any;
        lk_idx    = hit_idx;
        lk_ppn    = hit_any ? ent_ppn[hit_idx] : '0;
        lk_asn_o  = hit_any ? ent_asn[hit_idx] : '0;
        lk_glob   = hit_any & ent_glob[hit_idx];
        lk_rd_en  = hit_any ? ent_rd[hit_idx] : '0;
        lk_wr_en  = hit_any ? ent_wr[hit_idx] : '0;
        lk_flt_rd = hit_any & ent_frd[hit_idx];
        lk_flt_wr = hit_any & ent_fwr[hit_idx];
        lk_paddr  = {lk_ppn, lk_off};
    end

    // Expose the slot under the replacement pointer.
    always_comb begin
        vic_valid = ent_valid[vic_idx];
        vic_vpn   = ent_vpn[vic_idx];
        vic_ppn   = ent_ppn[vic_idx];
    end
endmodule

// File: rtl/astlb_chk.sv
// Temporal checks on the translation buffer, attached by bind.
// Assumes: reset is synchronous and active low.
module astlb_chk #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fl_all,
    input logic               fl_nonglob,
    input logic               fl_addr,
    input logic               ins_valid,
    input logic               vic_adv,
    input logic [IDX_W-1:0]   vic_idx,
    input logic               lk_hit,
    input logic [IDX_W-1:0]   lk_idx,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ent_glob
);
    logic fill_now;
    assign fill_now = ins_valid && !fl_all && !fl_nonglob && !fl_addr;

    a_r3_fill_marks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        fill_now |=> ent_valid[$past(vic_idx)]);

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_all && (fill_now || vic_adv)) |=>
        vic_idx == (($past(vic_idx) == IDX_W'(ENTRIES - 1)) ? '0 : $past(vic_idx) + 1'b1));

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (vic_idx == '0) && (ent_valid == '0));

    a_r5_local_gone: assert property (@(posedge clk) disable iff (!rst_n)
        fl_nonglob && !fl_all |=> (ent_valid & ~ent_glob) == '0);

    a_r1_hit_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ent_valid[lk_idx]);

    a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vic_idx) < ENTRIES);
endmodule

bind astlb astlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fl_all     (fl_all),
    .fl_nonglob (fl_nonglob),
    .fl_addr    (fl_addr),
    .ins_valid  (ins_valid),
    .vic_adv    (vic_adv),
    .vic_idx    (vic_idx),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .ent_valid  (ent_valid),
    .ent_glob   (ent_glob)
);

// File: tb/astlb_test.sv
`timescale 1ns/1ps
module astlb_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asn = '0;
    logic [12:0] lk_off = '0;
    logic        lk_hit;
    logic [2:0]  lk_idx;
    logic [19:0] lk_ppn;
    logic [7:0]  lk_asn_o;
    logic        lk_glob;
    logic [3:0]  lk_rd_en, lk_wr_en;
    logic        lk_flt_rd, lk_flt_wr;
    logic [32:0] lk_paddr;
    logic        ins_valid = 0, ins_glob = 0, ins_flt_rd = 0, ins_flt_wr = 0;
    logic [19:0] ins_vpn = '0, ins_ppn = '0;
    logic [7:0]  ins_asn = '0;
    logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
    logic        fl_all = 0, fl_nonglob = 0, fl_addr = 0, vic_adv = 0;
    logic [19:0] fl_vpn = '0;
    logic [7:0]  fl_asn = '0;
    logic [2:0]  vic_idx;
    logic        vic_valid;
    logic [19:0] vic_vpn, vic_ppn;

    astlb uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Op codes: 0 lookup check, 1 insert, 2 flush-all, 3 flush-nonglobal, 4 flush-page
    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asn;
        logic [19:0] ppn;
        logic        glob;
        logic        hit;
        logic [2:0]  idx;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [0:NV-1] = '{
        '{3'd1, 20'h100, 8'd1, 20'hAAA, 1'b0, 1'b0, 3'd0},
        '{3'd1, 20'h200, 8'd2, 20'hBBB, 1'b1, 1'b0, 3'd0},
        '{3'd1, 20'h100, 8'd3, 20'hCCC, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h100, 8'd1, 20'hAAA, 1'b0, 1'b1, 3'd0},
        '{3'd0, 20'h100, 8'd3, 20'hCCC, 1'b0, 1'b1, 3'd2},
        '{3'd0, 20'h100, 8'd5, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h200, 8'd9, 20'hBBB, 1'b0, 1'b1, 3'd1},
        '{3'd0, 20'h300, 8'd1, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd1, 20'h100, 8'd7, 20'hDDD, 1'b1, 1'b0, 3'd0},
        '{3'd0, 20'h100, 8'd3, 20'hCCC, 1'b0, 1'b1, 3'd2},
        '{3'd0, 20'h100, 8'd4, 20'hDDD, 1'b0, 1'b1, 3'd3},
        '{3'd4, 20'h100, 8'd3, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h100, 8'd3, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h100, 8'd1, 20'hAAA, 1'b0, 1'b1, 3'd0},
        '{3'd3, 20'h000, 8'd0, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h100, 8'd1, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h200, 8'd0, 20'hBBB, 1'b0, 1'b1, 3'd1},
        '{3'd2, 20'h000, 8'd0, 20'h000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 20'h200, 8'd0, 20'h000, 1'b0, 1'b0, 3'd0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        ins_valid = 0; fl_all = 0; fl_nonglob = 0; fl_addr = 0; vic_adv = 0;
    endtask

    task automatic do_ins(logic [19:0] v, logic [7:0] a, logic [19:0] p, logic g);
        ins_vpn = v; ins_asn = a; ins_ppn = p; ins_glob = g;
        ins_valid = 1; tick(); clear_in();
    endtask

    task automatic look(logic [19:0] v, logic [7:0] a);
        lk_vpn = v; lk_asn = a; #1;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1; #1;
        // R10: reset state
        look(20'h0, 8'd0);
        chk("R10 hit after reset", lk_hit, 0);
        chk("R10 pointer after reset", vic_idx, 0);
        chk("R10 victim slot invalid", vic_valid, 0);

        ins_rd_en = 4'hF; ins_wr_en = 4'hF;
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                3'd1: do_ins(TBL[i].vpn, TBL[i].asn, TBL[i].ppn, TBL[i].glob);
                3'd2: begin fl_all = 1; tick(); clear_in(); end
                3'd3: begin fl_nonglob = 1; tick(); clear_in(); end
                3'd4: begin fl_vpn = TBL[i].vpn; fl_asn = TBL[i].asn; fl_addr = 1; tick(); clear_in(); end
                default: begin
                    // R1 R2 R5 R6 R4: table checks
                    look(TBL[i].vpn, TBL[i].asn);
                    chk($sformatf("R1 row %0d hit", i), lk_hit, TBL[i].hit);
                    if (TBL[i].hit) begin
                        chk($sformatf("R2 row %0d idx", i), lk_idx, TBL[i].idx);
                        chk($sformatf("R1 row %0d ppn", i), lk_ppn, TBL[i].ppn);
                    end
                    tick();
                end
            endcase
        end
        chk("R4 pointer after flush-all", vic_idx, 0);

        // R11 + R7: fields returned and physical address
        ins_rd_en = 4'h5; ins_wr_en = 4'hA; ins_flt_rd = 1; ins_flt_wr = 0;
        do_ins(20'h4321, 8'd9, 20'h0F0F0, 0);
        ins_flt_rd = 0;
        lk_off = 13'h1ABC;
        look(20'h4321, 8'd9);
        chk("R11 rd enables", lk_rd_en, 4'h5);
        chk("R11 wr enables", lk_wr_en, 4'hA);
        chk("R11 fault-on-read", lk_flt_rd, 1);
        chk("R11 fault-on-write", lk_flt_wr, 0);
        chk("R11 global flag", lk_glob, 0);
        chk("R11 asn", lk_asn_o, 8'd9);
        chk("R7 physical address", lk_paddr, {20'h0F0F0, 13'h1ABC});
        chk("R3 pointer after insert", vic_idx, 1);

        // R8: stepping pointer without writing, wrap back to slot 0
        for (int k = 0; k < 7; k++) begin vic_adv = 1; tick(); clear_in(); end
        #1;
        chk("R8 pointer wrapped by advance", vic_idx, 0);
        chk("R8 victim valid", vic_valid, 1);
        chk("R8 victim tag", vic_vpn, 20'h4321);
        chk("R8 victim ppn", vic_ppn, 20'h0F0F0);
        look(20'h4321, 8'd9);
        chk("R8 advance left slot intact", lk_hit, 1);

        // R3: nine inserts into eight slots wrap to slot 0
        fl_all = 1; tick(); clear_in();
        for (int k = 0; k < 9; k++) do_ins(20'h10 + 20'(k), 8'd0, 20'h500 + 20'(k), 0);
        look(20'h10, 8'd0);
        chk("R3 oldest overwritten", lk_hit, 0);
        look(20'h18, 8'd0);
        chk("R3 wrapped insert hit", lk_hit, 1);
        chk("R3 wrapped insert idx", lk_idx, 0);
        chk("R3 pointer after wrap", vic_idx, 1);

        // R9: insert losing to flushes is dropped
        ins_vpn = 20'h77; ins_asn = 0; ins_valid = 1; fl_nonglob = 1; tick(); clear_in();
        look(20'h77, 8'd0);
        chk("R9 insert dropped under flush-nonglobal", lk_hit, 0);
        chk("R9 pointer held", vic_idx, 1);
        ins_vpn = 20'h78; ins_valid = 1; fl_all = 1; tick(); clear_in();
        look(20'h78, 8'd0);
        chk("R9 insert dropped under flush-all", lk_hit, 0);
        chk("R9 flush-all pointer", vic_idx, 0);

        finish_run();
    end
endmodule